// File: doc/BRIEF.md
# Power-On and Push-Button Reset Generator

This block drives an active-low system reset for a clocked digital domain. It takes a digital power-good indication, a debounced push-button level and a watchdog reset request. Whenever power is not valid the reset is asserted at once, without waiting for a clock edge. Once power returns, the reset is held for a fixed power-on interval before it is released.

While the system is running, two other sources can start a new reset cycle. A push-button press counts only if it lasts for a minimum width. Reset is then held for as long as the button stays down, and is stretched for a fixed interval counted from the release. A watchdog request starts a reset of its own fixed length. Neither source can start a cycle while one is already running.

All interval lengths are parameters counted in clock cycles. There is no data stream, so every pin is a plain control or status level. `pb_n` and `wd_req` must already be synchronous to `clk`.

Top module: `rstgen_top`

## Requirements
- R1: While `power_good` is low, `rst_n` is 0 and `in_reset` is 1, and this takes effect immediately without a clock edge.
- R2: After `power_good` rises, `rst_n` returns to 1 on the (TRST+1)-th rising clock edge.
- R3: A press is accepted only when `pb_n` is sampled low on TPBMIN consecutive edges while `rst_n` is 1. A shorter press has no effect, and a single high sample restarts the count.
- R4: After a press is accepted, `rst_n` is 0 from the accepting edge on, for as long as `pb_n` stays low.
- R5: `rst_n` returns to 1 on the TPBRST-th edge after the first edge that samples `pb_n` high following an accepted press.
- R6: A press made while a reset cycle is running is ignored, and it does not count toward the minimum width once the cycle ends.
- R7: When `wd_req` is sampled high while `rst_n` is 1, `rst_n` goes to 0 after that edge and returns to 1 TWDRST edges later. If a watchdog request and a press qualify on the same edge, the watchdog wins.
- R8: `wd_req` sampled while a reset cycle is running has no effect on when that cycle ends.
- R9: A loss of power during any reset cycle aborts it. When power returns, the full power-on interval of R2 is applied.
- R10: `in_reset` is always the inverse of `rst_n`.
- R11: Every period of `rst_n` low lasts at least the shortest of TRST, TPBRST and TWDRST cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| power_good | input | 1 | High when supply is valid; low clears the block asynchronously |
| pb_n | input | 1 | Debounced push-button, low while pressed |
| wd_req | input | 1 | Watchdog reset request, sampled each edge |
| rst_n | output | 1 | Active-low system reset |
| in_reset | output | 1 | High while any reset cycle is running |

## Verification
The hardest situations to reach are those where a second reset source acts while a cycle is already running. Examples are a button held long enough to qualify during the power-on interval, a watchdog request in the middle of a watchdog reset, and a power loss during a release stretch. The stimulus reaches them by counting clock edges from a known power-up and placing each disturbance a fixed number of edges into the running cycle. It then checks that the release edge falls exactly where the undisturbed cycle would put it, or, after a power loss, a full power-on interval later.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  typedef enum logic [2:0] {
    RG_OFF     = 3'd0,
    RG_POWERUP = 3'd1,
    RG_RUN     = 3'd2,
    RG_HELD    = 3'd3,
    RG_STRETCH = 3'd4,
    RG_WDOG    = 3'd5
  } rg_state_t;

  function automatic int unsigned rg_max3(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned rg_min3(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

endpackage

// File: rtl/rstgen_timer.sv
// Loadable down-counter: a load sets the count, and the count then falls by
// one each edge until it reaches zero, where it rests.
module rstgen_timer #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             expired
);

  logic [WIDTH-1:0] count_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign expired = (count_q == '0);

endmodule

// File: rtl/rstgen_pb_qual.sv
// Counts consecutive low samples of the button while enabled. It flags the
// edge that completes MIN_LOW of them.
module rstgen_pb_qual #(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic enable,
  input  logic pb_n,
  output logic qualified
);

  localparam int unsigned CW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_cnt_q;
  logic          at_last;

  assign at_last   = (low_cnt_q == LAST);
  assign qualified = enable && !pb_n && at_last;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt_q <= '0;
    end else if (!enable || pb_n) begin
      low_cnt_q <= '0;
    end else if (!at_last) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rstgen_ctrl.sv
// Sequencing of reset cycles. Each timed state is entered with its length
// minus one loaded into the shared timer, and it leaves on the edge that
// finds the timer expired.
module rstgen_ctrl
  import rstgen_pkg::*;
#(
  parameter int unsigned TRST   = 32,
  parameter int unsigned TPBRST = 20,
  parameter int unsigned TWDRST = 10,
  parameter int unsigned TW     = 6
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            pb_n,
  input  logic            pb_qual,
  input  logic            wd_req,
  input  logic            expired,
  output rg_state_t       state_q,
  output rg_state_t       state_d,
  output logic            tmr_load,
  output logic [TW-1:0]   tmr_val
);

  localparam logic [TW-1:0] POR_LOAD = TW'(TRST - 1);
  localparam logic [TW-1:0] PB_LOAD  = TW'(TPBRST - 1);
  localparam logic [TW-1:0] WD_LOAD  = TW'(TWDRST - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      RG_OFF: begin
        // The block only sees clock edges once power is valid.
        state_d  = RG_POWERUP;
        tmr_load = 1'b1;
        tmr_val  = POR_LOAD;
      end
      RG_POWERUP, RG_STRETCH, RG_WDOG: begin
        if (expired) state_d = RG_RUN;
      end
      RG_RUN: begin
        // The watchdog takes priority over a press that qualifies on the same edge.
        if (wd_req) begin
          state_d  = RG_WDOG;
          tmr_load = 1'b1;
          tmr_val  = WD_LOAD;
        end else if (pb_qual) begin
          state_d = RG_HELD;
        end
      end
      RG_HELD: begin
        if (pb_n) begin
          state_d  = RG_STRETCH;
          tmr_load = 1'b1;
          tmr_val  = PB_LOAD;
        end
      end
      default: state_d = RG_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= RG_OFF;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int unsigned TRST   = 32,
  parameter int unsigned TPBMIN = 4,
  parameter int unsigned TPBRST = 20,
  parameter int unsigned TWDRST = 10
) (
  input  logic clk,
  input  logic power_good,
  input  logic pb_n,
  input  logic wd_req,
  output logic rst_n,
  output logic in_reset
);

  localparam int unsigned MAXT = rg_max3(TRST, TPBRST, TWDRST);
  localparam int unsigned TW   = $clog2(MAXT + 1);

  rg_state_t       state_q;
  rg_state_t       state_d;
  logic            tmr_load;
  logic [TW-1:0]   tmr_val;
  logic            expired;
  logic            pb_qual;
  logic            run_now;
  logic            rst_q;

  assign run_now = (state_q == RG_RUN);

  rstgen_pb_qual #(.MIN_LOW(TPBMIN)) pb_qual_i (
    .clk       (clk),
    .arst_n    (power_good),
    .enable    (run_now),
    .pb_n      (pb_n),
    .qualified (pb_qual)
  );

  rstgen_timer #(.WIDTH(TW)) timer_i (
    .clk      (clk),
    .arst_n   (power_good),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  rstgen_ctrl #(
    .TRST   (TRST),
    .TPBRST (TPBRST),
    .TWDRST (TWDRST),
    .TW     (TW)
  ) ctrl_i (
    .clk      (clk),
    .arst_n   (power_good),
    .pb_n     (pb_n),
    .pb_qual  (pb_qual),
    .wd_req   (wd_req),
    .expired  (expired),
    .state_q  (state_q),
    .state_d  (state_d),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  // The reset output comes from its own flop, so it cannot glitch.
  always_ff @(posedge clk or negedge power_good) begin
    if (!power_good) rst_q <= 1'b0;
    else             rst_q <= (state_d == RG_RUN);
  end

  assign rst_n    = rst_q;
  assign in_reset = !run_now;

endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk #(
  parameter int unsigned TRST   = 32,
  parameter int unsigned TPBMIN = 4,
  parameter int unsigned TPBRST = 20,
  parameter int unsigned TWDRST = 10
) (
  input logic clk,
  input logic power_good,
  input logic pb_n,
  input logic wd_req,
  input logic rst_n,
  input logic in_reset
);

  localparam int MINLOW = int'(rstgen_pkg::rg_min3(TRST, TPBRST, TWDRST));

  int low_run;
  int pb_run;

  always_ff @(posedge clk or negedge power_good) begin
    if (!power_good) begin
      low_run <= 0;
      pb_run  <= 0;
    end else begin
      if (rst_n) low_run <= 0;
      else if (low_run < MINLOW) low_run <= low_run + 1;
      if (!rst_n || pb_n) pb_run <= 0;
      else if (pb_run < int'(TPBMIN) - 1) pb_run <= pb_run + 1;
    end
  end

  // R1
  power_low_chk: assert property (@(posedge clk) !power_good |-> !rst_n);

  // R10
  flag_match_chk: assert property (@(posedge clk) disable iff (!power_good)
    rst_n != in_reset);

  // R3
  short_press_chk: assert property (@(posedge clk) disable iff (!power_good)
    rst_n && !wd_req && (pb_n || pb_run < int'(TPBMIN) - 1) |=> rst_n);

  // R4
  press_accept_chk: assert property (@(posedge clk) disable iff (!power_good)
    rst_n && !pb_n && pb_run == int'(TPBMIN) - 1 |=> !rst_n);

  // R7
  wdog_start_chk: assert property (@(posedge clk) disable iff (!power_good)
    rst_n && wd_req |=> !rst_n);

  // R11
  min_low_chk: assert property (@(posedge clk) disable iff (!power_good)
    $rose(rst_n) |-> low_run >= MINLOW);

endmodule

bind rstgen_top rstgen_chk #(
  .TRST   (TRST),
  .TPBMIN (TPBMIN),
  .TPBRST (TPBRST),
  .TWDRST (TWDRST)
) chk_i (
  .clk        (clk),
  .power_good (power_good),
  .pb_n       (pb_n),
  .wd_req     (wd_req),
  .rst_n      (rst_n),
  .in_reset   (in_reset)
);

// File: tb/rstgen_top_tb_top.sv
module rstgen_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TRST   = 32;
  localparam int TPBMIN = 4;
  localparam int TPBRST = 20;
  localparam int TWDRST = 10;

  typedef struct packed {
    logic [1:0] op;      // 1 = button press, 2 = watchdog pulse
    logic [7:0] width;   // press length in edges
    logic       accept;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'(TPBMIN - 1),  1'b0},
    '{2'd1, 8'd1,            1'b0},
    '{2'd1, 8'(TPBMIN),      1'b1},
    '{2'd1, 8'(TPBMIN + 25), 1'b1},
    '{2'd2, 8'd0,            1'b1},
    '{2'd1, 8'(TPBMIN + 1),  1'b1},
    '{2'd2, 8'd0,            1'b1}
  };

  logic clk;
  logic power_good;
  logic pb_n;
  logic wd_req;
  logic rst_n;
  logic in_reset;

  int n_chk;
  int n_fail;

  rstgen_top #(
    .TRST   (TRST),
    .TPBMIN (TPBMIN),
    .TPBRST (TPBRST),
    .TWDRST (TWDRST)
  ) dut_i (
    .clk        (clk),
    .power_good (power_good),
    .pb_n       (pb_n),
    .wd_req     (wd_req),
    .rst_n      (rst_n),
    .in_reset   (in_reset)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Checks rst_n and, for R10, that in_reset is its inverse.
  task automatic check_rst(input string req, input logic exp);
    n_chk++;
    if (rst_n !== exp || in_reset !== !exp) begin
      n_fail++;
      $display("FAIL %s: rst_n=%0b in_reset=%0b expected rst_n=%0b in_reset=%0b (R10)",
               req, rst_n, in_reset, exp, !exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    power_good = 1'b0;
    pb_n = 1'b1;
    wd_req = 1'b0;

    // R1: reset state with power invalid
    tick(3);
    check_rst("R1 power off", 1'b0);

    // R2: power-on interval
    power_good = 1'b1;
    tick(TRST);
    check_rst("R2 still in power-on", 1'b0);
    tick(1);
    check_rst("R2 released", 1'b1);
    tick(3);

    // Table walk: presses of several widths and watchdog pulses
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd1) begin
        pb_n = 1'b0;
        tick(int'(VECS[i].width));
        if (VECS[i].accept) check_rst("R4 held while pressed", 1'b0);
        else                check_rst("R3 short press ignored", 1'b1);
        pb_n = 1'b1;
        if (VECS[i].accept) begin
          tick(TPBRST);
          check_rst("R5 stretch running", 1'b0);
          tick(1);
          check_rst("R5 stretch ended", 1'b1);
        end else begin
          tick(TPBRST + 1);
          check_rst("R3 no reset after short press", 1'b1);
        end
      end else begin
        wd_req = 1'b1;
        tick(1);
        wd_req = 1'b0;
        check_rst("R7 watchdog reset started", 1'b0);
        tick(TWDRST - 1);
        check_rst("R7 R11 watchdog reset running", 1'b0);
        tick(1);
        check_rst("R7 watchdog reset ended", 1'b1);
      end
      tick(3);
    end

    // R3: two short presses split by one high sample do not add up
    pb_n = 1'b0;
    tick(TPBMIN - 1);
    pb_n = 1'b1;
    tick(1);
    pb_n = 1'b0;
    tick(TPBMIN - 1);
    pb_n = 1'b1;
    tick(2);
    check_rst("R3 split press ignored", 1'b1);
    tick(3);

    // R6: press during power-on interval is ignored
    power_good = 1'b0;
    #1;
    check_rst("R1 immediate on power loss", 1'b0);
    tick(1);
    power_good = 1'b1;
    tick(2);
    pb_n = 1'b0;
    tick(TPBMIN + 2);
    pb_n = 1'b1;
    tick(TRST + 1 - (TPBMIN + 4));
    check_rst("R6 power-on end unaffected by press", 1'b1);
    tick(TPBRST + 2);
    check_rst("R6 no stretch from ignored press", 1'b1);

    // R8: watchdog request during a watchdog reset is ignored
    wd_req = 1'b1;
    tick(1);
    wd_req = 1'b0;
    tick(2);
    wd_req = 1'b1;
    tick(1);
    wd_req = 1'b0;
    tick(TWDRST + 1 - 4);
    check_rst("R8 release on original schedule", 1'b1);
    tick(5);
    check_rst("R8 no extra reset", 1'b1);

    // R9: power loss during a release stretch restarts power-on
    pb_n = 1'b0;
    tick(TPBMIN + 1);
    pb_n = 1'b1;
    tick(3);
    power_good = 1'b0;
    #1;
    check_rst("R9 power loss aborts stretch", 1'b0);
    tick(2);
    power_good = 1'b1;
    tick(TRST);
    check_rst("R9 full power-on applied", 1'b0);
    tick(1);
    check_rst("R9 released after power-on", 1'b1);

    summary();
  end

endmodule